// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one integer by another over several clock cycles and returns a quotient and a remainder. It uses restoring division and settles one quotient bit per clock. The divisor stays fixed in its own register. A double-width remainder accumulator moves left by one place each iteration, and the quotient bits fill the low half as that half empties. One subtractor, as wide as an operand plus a carry bit, serves every iteration.

A caller presents both operands and a signed/unsigned select, then pulses `start_i` while the block is idle. `busy_o` stays high while the iterations run. `done_o` pulses once when the result is ready. The quotient appears on `lo_o` and the remainder on `hi_o`, and both hold until the next division completes. In signed mode the block divides the magnitudes and fixes the signs of the results afterwards. A zero divisor raises a flag, and the results it produces are undefined but stable.

Top module: `seq_restoring_div`

## Requirements
- R1: In unsigned mode (`signed_i` = 0), `lo_o` equals the floor of dividend / divisor once `done_o` pulses, for every nonzero divisor. For example, 74 / 8 gives 9.
- R2: In unsigned mode, `hi_o` equals dividend mod divisor once `done_o` pulses. For example, 74 / 8 leaves 2.
- R3: In signed mode (`signed_i` = 1, two's complement operands), `lo_o` is the quotient truncated toward zero. It is negative when the operand signs differ, and it keeps only its low DATA_W bits, so the most negative value divided by -1 returns the most negative value.
- R4: In signed mode, `hi_o` is the remainder. It carries the sign of the dividend, and its magnitude is less than the magnitude of the divisor.
- R5: Once a start is accepted, `busy_o` is high for exactly DATA_W cycles. `done_o` is high for exactly one cycle, the cycle after the last busy cycle, and it is never high together with `busy_o`.
- R6: A start pulse while `busy_o` is high is ignored: the operation in flight keeps its operands and its timing.
- R7: A zero divisor sets `div_zero_o`. The flag holds until the next accepted start, and `lo_o`/`hi_o` stay stable after the `done_o` pulse. A nonzero divisor clears the flag.
- R8: After reset, `busy_o`, `done_o` and `div_zero_o` are 0, and `lo_o` and `hi_o` are all zeros.
- R9: `lo_o` and `hi_o` change only in the cycle in which `done_o` is high, and they hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only while idle |
| signed_i | input | 1 | 1: two's complement operands, 0: unsigned |
| dividend_i | input | DATA_W | Dividend |
| divisor_i | input | DATA_W | Divisor |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle completion pulse |
| div_zero_o | output | 1 | Last accepted divisor was zero |
| lo_o | output | DATA_W | Quotient |
| hi_o | output | DATA_W | Remainder |

## Verification
The bench builds two instances. The first uses DATA_W = 4. It is swept over every dividend, every divisor and both signedness modes, so the most-negative-by-minus-one wrap, all sign combinations and every zero-divisor case are covered in full. The second uses the default DATA_W = 32 and runs directed cases: the 74 / 8 example, signed variants of it, full-scale operands, and a start pulse issued in the middle of a run. Busy length and done timing are measured at both widths.

// File: rtl/seq_div_pkg.sv
package seq_div_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic              signed_i,
  output logic [DATA_W-1:0] mag_o,
  output logic              neg_o
);
  assign neg_o = signed_i & val_i[DATA_W-1];
  assign mag_o = neg_o ? (~val_i + DATA_W'(1)) : val_i;
endmodule

// File: rtl/div_restore_step.sv
module div_restore_step #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              ovf_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] divisor_i,
  input  logic              last_i,
  output logic              ovf_o,
  output logic [DATA_W-1:0] hi_o,
  output logic [DATA_W-1:0] lo_o
);
  logic [DATA_W:0]   diff;
  logic              q_bit;
  logic [DATA_W-1:0] kept_hi;

  // trial subtract on the upper half plus the bit shifted out last time
  assign diff    = {ovf_i, hi_i} - {1'b0, divisor_i};
  assign q_bit   = ~diff[DATA_W];
  assign kept_hi = q_bit ? diff[DATA_W-1:0] : hi_i;

  always_comb begin
    if (last_i) begin
      // final step: the upper half already holds the remainder
      ovf_o = 1'b0;
      hi_o  = kept_hi;
    end else begin
      ovf_o = kept_hi[DATA_W-1];
      hi_o  = {kept_hi[DATA_W-2:0], lo_i[DATA_W-1]};
    end
    lo_o = {lo_i[DATA_W-2:0], q_bit};
  end
endmodule

// File: rtl/div_result_fix.sv
module div_result_fix #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] quo_i,
  input  logic [DATA_W-1:0] rem_i,
  input  logic              neg_quo_i,
  input  logic              neg_rem_i,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] hi_o
);
  assign lo_o = neg_quo_i ? (~quo_i + DATA_W'(1)) : quo_i;
  assign hi_o = neg_rem_i ? (~rem_i + DATA_W'(1)) : rem_i;
endmodule

// File: rtl/seq_restoring_div.sv
module seq_restoring_div
  import seq_div_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              signed_i,
  input  logic [DATA_W-1:0] dividend_i,
  input  logic [DATA_W-1:0] divisor_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              div_zero_o,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] hi_o
);
  localparam int unsigned CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  div_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ovf_q;
  logic [DATA_W-1:0] acc_hi_q, acc_lo_q, dvs_q;
  logic              neg_quo_q, neg_rem_q;
  logic              dz_q, done_q;
  logic [DATA_W-1:0] lo_q, hi_q;

  logic [DATA_W-1:0] dvd_mag, dvs_mag;
  logic              dvd_neg, dvs_neg;
  logic              last;
  logic              step_ovf;
  logic [DATA_W-1:0] step_hi, step_lo;
  logic [DATA_W-1:0] fix_lo, fix_hi;
  logic              accept;

  div_operand_prep #(.DATA_W(DATA_W)) dvd_prep_i (
    .val_i(dividend_i), .signed_i(signed_i), .mag_o(dvd_mag), .neg_o(dvd_neg)
  );

  div_operand_prep #(.DATA_W(DATA_W)) dvs_prep_i (
    .val_i(divisor_i), .signed_i(signed_i), .mag_o(dvs_mag), .neg_o(dvs_neg)
  );

  assign last = (cnt_q == '0);

  div_restore_step #(.DATA_W(DATA_W)) step_i (
    .ovf_i(ovf_q), .hi_i(acc_hi_q), .lo_i(acc_lo_q), .divisor_i(dvs_q),
    .last_i(last), .ovf_o(step_ovf), .hi_o(step_hi), .lo_o(step_lo)
  );

  div_result_fix #(.DATA_W(DATA_W)) fix_i (
    .quo_i(step_lo), .rem_i(step_hi), .neg_quo_i(neg_quo_q),
    .neg_rem_i(neg_rem_q), .lo_o(fix_lo), .hi_o(fix_hi)
  );

  assign accept = start_i & (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      ovf_q     <= 1'b0;
      acc_hi_q  <= '0;
      acc_lo_q  <= '0;
      dvs_q     <= '0;
      neg_quo_q <= 1'b0;
      neg_rem_q <= 1'b0;
      dz_q      <= 1'b0;
      done_q    <= 1'b0;
      lo_q      <= '0;
      hi_q      <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        // load the dividend magnitude low, clear high, pre-shift by one
        state_q   <= ST_RUN;
        cnt_q     <= LAST_IDX;
        ovf_q     <= 1'b0;
        acc_hi_q  <= {{(DATA_W-1){1'b0}}, dvd_mag[DATA_W-1]};
        acc_lo_q  <= {dvd_mag[DATA_W-2:0], 1'b0};
        dvs_q     <= dvs_mag;
        neg_quo_q <= dvd_neg ^ dvs_neg;
        neg_rem_q <= dvd_neg;
        dz_q      <= (divisor_i == '0);
      end else if (state_q == ST_RUN) begin
        ovf_q    <= step_ovf;
        acc_hi_q <= step_hi;
        acc_lo_q <= step_lo;
        cnt_q    <= cnt_q - CNT_W'(1);
        if (last) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          lo_q    <= fix_lo;
          hi_q    <= fix_hi;
        end
      end
    end
  end

  assign busy_o     = (state_q == ST_RUN);
  assign done_o     = done_q;
  assign div_zero_o = dz_q;
  assign lo_o       = lo_q;
  assign hi_o       = hi_q;
endmodule

// File: rtl/seq_div_chk.sv
module seq_div_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_i,
  input logic              done_i,
  input logic              dz_i,
  input logic [DATA_W-1:0] lo_i,
  input logic [DATA_W-1:0] hi_i
);
  localparam int unsigned RUN_W = $clog2(DATA_W + 1) + 1;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else         run_q <= busy_i ? run_q + RUN_W'(1) : '0;
  end

  // R5 R6
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (run_q < RUN_W'(DATA_W)));

  // R5
  busy_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> (run_q == RUN_W'(DATA_W)) && done_i);

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  // R5
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_i && done_i));

  // R5
  launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i) |=> busy_i);

  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> ($stable(lo_i) && $stable(hi_i)));

  // R7
  dz_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_i && !busy_i) |=> $stable(dz_i));
endmodule

bind seq_restoring_div seq_div_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_i(busy_o),
  .done_i(done_o), .dz_i(div_zero_o), .lo_i(lo_o), .hi_i(hi_o)
);

// File: tb/seq_restoring_div_tb_top.sv
`timescale 1ns/1ps
module seq_restoring_div_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // narrow instance
  logic       st4 = 0, sg4 = 0;
  logic [3:0] a4 = '0, b4 = '0;
  logic       busy4, done4, dz4;
  logic [3:0] lo4, hi4;

  seq_restoring_div #(.DATA_W(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(st4), .signed_i(sg4),
    .dividend_i(a4), .divisor_i(b4), .busy_o(busy4), .done_o(done4),
    .div_zero_o(dz4), .lo_o(lo4), .hi_o(hi4)
  );

  // full-width instance
  logic        st32 = 0, sg32 = 0;
  logic [31:0] a32 = '0, b32 = '0;
  logic        busy32, done32, dz32;
  logic [31:0] lo32, hi32;

  seq_restoring_div dut32_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(st32), .signed_i(sg32),
    .dividend_i(a32), .divisor_i(b32), .busy_o(busy32), .done_o(done32),
    .div_zero_o(dz32), .lo_o(lo32), .hi_o(hi32)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint ext(input logic [31:0] v, input int w, input logic s);
    longint r = longint'(v);
    if (s && v[w-1]) r = r - (longint'(1) << w);
    return r;
  endfunction

  task automatic op4(input logic [3:0] a, input logic [3:0] b, input logic s, output int nb);
    @(negedge clk); st4 = 1; a4 = a; b4 = b; sg4 = s;
    @(negedge clk); st4 = 0; nb = 0;
    while (!done4) begin if (busy4) nb++; @(negedge clk); end
  endtask

  task automatic op32(input logic [31:0] a, input logic [31:0] b, input logic s,
                      input bit poke, output int nb);
    @(negedge clk); st32 = 1; a32 = a; b32 = b; sg32 = s;
    @(negedge clk); st32 = 0; nb = 0;
    while (!done32) begin
      if (busy32) nb++;
      if (poke && nb == 3) begin st32 = 1; a32 = 32'd5; b32 = 32'd5; sg32 = 0; end
      else st32 = 0;
      @(negedge clk);
    end
    st32 = 0;
  endtask

  task automatic expect32(input logic [31:0] a, input logic [31:0] b, input logic s, input bit poke);
    int nb;
    longint sa, sb, q, r;
    sa = ext(a, 32, s); sb = ext(b, 32, s);
    q = sa / sb; r = sa % sb;
    op32(a, b, s, poke, nb);
    chk(lo32 == q[31:0], s ? "R3 quotient w32" : "R1 quotient w32", lo32, q[31:0]);
    chk(hi32 == r[31:0], s ? "R4 remainder w32" : "R2 remainder w32", hi32, r[31:0]);
    chk(nb == 32, "R5 busy length w32", nb, 32);
    if (poke) chk(lo32 == q[31:0] && nb == 32, "R6 start while busy ignored", lo32, q[31:0]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int nb;
    logic [3:0] lo_keep, hi_keep;
    longint sa, sb, q, r;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(!busy4 && !done4 && !dz4 && lo4 == 0 && hi4 == 0, "R8 reset w4", {busy4, done4, dz4, lo4, hi4}, 0);
    chk(!busy32 && !done32 && !dz32 && lo32 == 0 && hi32 == 0, "R8 reset w32", lo32, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // exhaustive narrow sweep
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          op4(4'(a), 4'(b), 1'(s), nb);
          @(negedge clk);
          chk(!done4, "R5 done single cycle", done4, 0);
          if (nb != 4) chk(0, "R5 busy length w4", nb, 4);
          if (b == 0) begin
            chk(dz4, "R7 zero flag set", dz4, 1);
            lo_keep = lo4; hi_keep = hi4;
            repeat (3) @(negedge clk);
            chk(lo4 == lo_keep && hi4 == hi_keep && dz4, "R7 results stable", lo4, lo_keep);
          end else begin
            sa = ext(32'(a), 4, 1'(s)); sb = ext(32'(b), 4, 1'(s));
            q = sa / sb; r = sa % sb;
            chk(!dz4, "R7 zero flag clear", dz4, 0);
            chk(lo4 == q[3:0], s ? "R3 quotient w4" : "R1 quotient w4", lo4, q[3:0]);
            chk(hi4 == r[3:0], s ? "R4 remainder w4" : "R2 remainder w4", hi4, r[3:0]);
          end
        end
      end
    end

    // R9 hold after completion
    op4(4'd13, 4'd3, 1'b0, nb);
    repeat (5) @(negedge clk);
    chk(lo4 == 4'd4 && hi4 == 4'd1, "R9 result held", {lo4, hi4}, {4'd4, 4'd1});

    // full width directed
    expect32(32'd74, 32'd8, 1'b0, 1'b0);
    chk(lo32 == 32'd9 && hi32 == 32'd2, "R1 R2 example 74/8", {lo32, hi32}, {32'd9, 32'd2});
    expect32(-32'sd74, 32'd8, 1'b1, 1'b0);
    expect32(32'd74, -32'sd8, 1'b1, 1'b0);
    expect32(-32'sd74, -32'sd8, 1'b1, 1'b0);
    expect32(32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0);
    expect32(32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b0, 1'b0);
    expect32(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0);
    expect32(32'h7FFF_FFFF, 32'h0001_0003, 1'b1, 1'b0);
    expect32(32'd1000, 32'd7, 1'b0, 1'b1);
    op32(32'd99, 32'd0, 1'b0, 1'b0, nb);
    chk(dz32, "R7 zero flag w32", dz32, 1);
    expect32(32'd99, 32'd10, 1'b0, 1'b0);
    chk(!dz32, "R7 flag cleared w32", dz32, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule